// File: doc/BRIEF.md
# Serially Programmed Dual Divider Pair

This block holds two programmable frequency dividers and the three-wire serial port that sets their ratios. One divider counts cycles of the block clock, which is the reference clock, and gives the divided reference output. The other counts rising edges of an incoming oscillator signal and gives the divided feedback output. Each output is a one-clock-wide pulse once per divide period. Both outputs are brought out at the pins, so either divider can also be used on its own.

A host shifts in a 15-bit frame on the serial data and serial clock pins. The frame is the 14-bit ratio, most significant bit first, followed by one steering bit. A high pulse on the load pin then copies the ratio into the latch the steering bit selects. The counters keep their current period until the new ratio is picked up at their next reload. The bit leaving the far end of the shift register is driven on a serial output, so further shift registers can be chained behind this one. All serial pins and the oscillator input are synchronised to the block clock with two flops, and their edges are detected in that clock domain.

Top module: `serial_dual_divider`

## Requirements
- R1: On each rising edge of `ser_clk`, the shift register takes one bit from `ser_data`. A frame is 14 ratio bits, most significant first, then one steering bit. After a full frame, the ratio is in shift bits [14:1] and the steering bit is in bit [0].
- R2: While `ser_load` is high, the ratio in the shift register is copied into the reference latch when the steering bit is 1, and into the feedback latch when it is 0. The latch that is not selected keeps its value.
- R3: While `ser_load` is low, shifting changes neither latch, so both output periods stay the same.
- R4: A ratio below 3 is stored as 3. Ratios from 3 to 16383 are stored as given.
- R5: `ref_div_out` is a one-cycle pulse that repeats every N clock cycles, where N is the reference latch value.
- R6: `fb_div_out` is a one-cycle pulse that repeats every M rising edges of `vco_in`, where M is the feedback latch value.
- R7: A newly latched ratio takes effect at the divider's next reload. The period that is running when the load happens finishes at its old length.
- R8: `ser_out` is shift bit [14], which is the first bit of the last 15 bits shifted in.
- R9: After reset, both latches hold 3, the shift register is clear, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the reference divider counts its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; a bit is taken on each rising edge |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load pulse; while high, copies the frame into the selected latch |
| vco_in | input | 1 | Oscillator input counted by the feedback divider |
| ref_div_out | output | 1 | Divided reference pulse |
| fb_div_out | output | 1 | Divided feedback pulse |
| ser_out | output | 1 | Serial output from the end of the shift register |

## Verification
Each serial pin passes through two synchroniser flops and then an edge-detect flop. A shift therefore lands about three clock cycles after the `ser_clk` rise, and a latch update about three cycles after `ser_load` rises. The bench holds every serial level for four clock cycles, so each bit and each load is settled before the next edge, and it reads `ser_out` only after the frame has finished. The divided outputs are judged by the interval between two pulses, counted on falling clock edges. This makes the fixed pipeline latency cancel out. After a load, the first interval is discarded, because the period running at that moment still has the old length; the R7 test measures that period on purpose. The feedback interval is expected to be six clock cycles per ratio step, because the bench's `vco_in` has a period of six clock cycles.

// File: rtl/serial_dual_divider.sv
module serial_dual_divider #(
  parameter int W         = 14,
  parameter int MIN_RATIO = 3,
  parameter int DEF_RATIO = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_load,
  input  logic vco_in,
  output logic ref_div_out,
  output logic fb_div_out,
  output logic ser_out
);
  localparam int FRAME = W + 1;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] MINV = W'(MIN_RATIO);
  localparam logic [W-1:0] DEFV = W'(DEF_RATIO);

  logic [2:0]       sck_q, vco_q;
  logic [1:0]       dat_q, ld_q;
  logic [FRAME-1:0] sr;
  logic [W-1:0]     ref_lat, fb_lat, ref_cnt, fb_cnt;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire vco_rise = vco_q[1] & ~vco_q[2];
  wire [W-1:0] ratio_in  = sr[FRAME-1:1];
  wire [W-1:0] ratio_cl  = (ratio_in < MINV) ? MINV : ratio_in;

  assign ser_out = sr[FRAME-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; vco_q <= '0; dat_q <= '0; ld_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], ser_clk};
      vco_q <= {vco_q[1:0], vco_in};
      dat_q <= {dat_q[0], ser_data};
      ld_q  <= {ld_q[0], ser_load};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (sck_rise) sr <= {sr[FRAME-2:0], dat_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_lat <= DEFV;
      fb_lat  <= DEFV;
    end else if (ld_q[1]) begin
      if (sr[0]) ref_lat <= ratio_cl;
      else       fb_lat  <= ratio_cl;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt     <= DEFV - ONE;
      ref_div_out <= 1'b0;
    end else begin
      ref_cnt     <= (ref_cnt == '0) ? ref_lat - ONE : ref_cnt - ONE;
      ref_div_out <= (ref_cnt == '0);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fb_cnt     <= DEFV - ONE;
      fb_div_out <= 1'b0;
    end else begin
      if (vco_rise) fb_cnt <= (fb_cnt == '0) ? fb_lat - ONE : fb_cnt - ONE;
      fb_div_out <= vco_rise && (fb_cnt == '0);
    end

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) ref_lat >= MINV && fb_lat >= MINV); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_q[1] |=> $stable(ref_lat) && $stable(fb_lat)); // R3
  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ref_div_out |=> !ref_div_out); // R5
  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fb_div_out |=> !fb_div_out); // R6
endmodule

// File: tb/serial_dual_divider_tb_top.sv
module serial_dual_divider_tb_top;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_load = 0, vco_in = 0;
  logic ref_div_out, fb_div_out, ser_out;
  int checks = 0, errors = 0, cycles = 0;
  int cur_ref = 3, cur_fb = 3;
  localparam int VCO_HALF = 3;
  localparam int VN = 6;
  localparam int V_CTRL [VN]  = '{1, 1, 0, 0, 1, 0};
  localparam int V_RATIO[VN]  = '{5, 100, 4, 37, 2, 0};
  localparam int V_EXP  [VN]  = '{5, 100, 4, 37, 3, 3};

  serial_dual_divider dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .vco_in(vco_in), .ref_div_out(ref_div_out), .fb_div_out(fb_div_out),
    .ser_out(ser_out));

  always #5 clk = ~clk;
  initial forever begin repeat (VCO_HALF) @(negedge clk); vco_in = ~vco_in; end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_data = b;
    repeat (4) @(negedge clk); ser_clk = 1;
    repeat (4) @(negedge clk); ser_clk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input int ratio, input logic ctrl, input bit load);
    logic [13:0] r = 14'(ratio);
    for (int i = 13; i >= 0; i--) shift_bit(r[i]);
    shift_bit(ctrl);
    if (load) begin
      repeat (4) @(negedge clk); ser_load = 1;
      repeat (4) @(negedge clk); ser_load = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic ref_period(output int p);
    do @(negedge clk); while (!ref_div_out);
    p = 0;
    do begin @(negedge clk); p++; end while (!ref_div_out);
  endtask

  task automatic fb_period(output int p);
    do @(negedge clk); while (!fb_div_out);
    p = 0;
    do begin @(negedge clk); p++; end while (!fb_div_out);
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    check("R9 ref_div_out in reset", ref_div_out, 0);
    check("R9 fb_div_out in reset", fb_div_out, 0);
    check("R9 ser_out in reset", ser_out, 0);
    rst_n = 1;
    ref_period(p); ref_period(p); check("R9 default ref period", p, 3);
    fb_period(p);  fb_period(p);  check("R9 default fb period", p, 3 * 2 * VCO_HALF);

    for (int v = 0; v < VN; v++) begin
      string tag;
      send_frame(V_RATIO[v], V_CTRL[v] != 0, 1);
      tag = (V_EXP[v] != V_RATIO[v]) ? "R4 clamp" : (V_CTRL[v] != 0) ? "R1/R5 ref" : "R1/R6 fb";
      if (V_CTRL[v] != 0) cur_ref = V_EXP[v]; else cur_fb = V_EXP[v];
      ref_period(p); ref_period(p); check({tag, " ref period"}, p, cur_ref);
      fb_period(p);  fb_period(p);  check({tag, " R2 fb period"}, p, cur_fb * 2 * VCO_HALF);
    end

    send_frame(14'h2001, 1'b1, 0);
    check("R8 ser_out first bit of frame", ser_out, 1);
    ref_period(p); ref_period(p); check("R3 ref unchanged without load", p, cur_ref);
    fb_period(p); check("R3 fb unchanged without load", p, cur_fb * 2 * VCO_HALF);
    send_frame(5, 1'b1, 0);
    check("R8 ser_out after second frame", ser_out, 0);

    send_frame(200, 1'b1, 1);
    cur_ref = 200;
    send_frame(10, 1'b1, 0);
    ref_period(p); ref_period(p); check("R7 ref period before reload", p, 200);
    do @(negedge clk); while (!ref_div_out);
    ser_load = 1;
    p = 0;
    do begin
      @(negedge clk); p++;
      if (p == 4) ser_load = 0;
    end while (!ref_div_out);
    check("R7 running period not truncated", p, 200);
    ref_period(p); check("R7 new period after reload", p, 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule